// File: doc/BRIEF.md
# Equivalent-Time Sample Strobe Sequencer

This block drives the conversion strobe of an ADC that samples a repetitive waveform in equivalent time. An external comparator pulses a trigger each time the waveform crosses its trigger level. The block answers each accepted trigger with exactly one single-clock conversion strobe. Before that strobe it waits a delay that starts at zero and grows by a programmed step on every later trigger. As a result, successive waveform periods are sampled at successively later points. Rebuilt in order, the samples form one period at an effective sample interval equal to the step.

Software arms the block with a step, in block clock cycles, and a sample total. The block then accepts triggers one at a time. It raises done together with the last strobe and holds done until the next arm. The trigger input is asynchronous. It is brought into the clock domain by two flops and acts only on its rising edge.

Top module: `ets_sample_sequencer`

## Requirements
- R1: After reset, conv_o and done_o are low, and triggers that arrive before the first arm produce no strobe.
- R2: Each accepted trigger produces exactly one conv_o strobe, one clock cycle wide.
- R3: The strobe for sample k (k counting from 0 within an acquisition) rises exactly k*step+4 rising clock edges after the first edge at which trig_i is sampled high. The fixed 4 is two synchronizer flops, the edge register and the strobe register.
- R4: Only a rising edge of trig_i counts, so a trigger held high for many cycles is accepted once.
- R5: A trigger whose rising edge arrives while a delay countdown is running is ignored and produces no extra strobe.
- R6: Once the programmed number of samples has been issued, done_o rises in the same cycle as the last strobe. No strobe follows, and done_o stays high until the next arm.
- R7: Arming with a sample total of 0 raises done_o on the edge that samples arm_i, and no strobe is ever issued.
- R8: An arm at any time restarts the acquisition. It clears done_o, resets the sample index and the delay to zero, and drops a pending countdown without a strobe.
- R9: When arm_i and a trigger edge are acted on at the same clock edge, the arm wins and that trigger is dropped.
- R10: step_i and count_i are captured on the arm edge. Later changes to them have no effect on the running acquisition.
- R11: With a step of 0, every strobe lands at the same trigger-relative latency of 4 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; delays are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm_i | input | 1 | One-cycle request to start a new acquisition |
| step_i | input | STEP_W | Delay increment per sample, in clock cycles |
| count_i | input | CNT_W | Number of samples in the acquisition |
| trig_i | input | 1 | Asynchronous trigger from the level comparator |
| conv_o | output | 1 | One-cycle ADC conversion strobe |
| done_o | output | 1 | High once all samples are issued, until the next arm |

## Verification
The arm can coincide with a trigger edge, and the last strobe coincides with the rise of done. The bench provokes the first case by raising arm_i exactly two cycles after the trigger. That puts the arm on the edge where the synchronized trigger edge is acted on. It then expects no strobe, followed by a delay-zero strobe on the next trigger, since the index was reset. For the second case, the bench logs the cycle of every strobe and the cycle where done rises, and requires the latter to equal the computed cycle of the final strobe. It also requires that no strobe follows once done is high, including for triggers that arrive afterwards.

// File: rtl/ets_pkg.sv
package ets_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/ets_rst_sync.sv
module ets_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/ets_trig_edge.sv
module ets_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic rise
);

  logic meta_q;
  logic sync_q;
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= trig_async;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;

  // a held trigger yields a single edge pulse
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R4

endmodule

// File: rtl/ets_delay_timer.sv
module ets_delay_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         fire,
  output logic         busy
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         busy_q, busy_d;
  logic         en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (clr) begin
      busy_d = 1'b0;
    end else if (load && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = load_val;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  assign en = clr | load | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign fire = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  // the controller never reloads a running countdown
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q); // R5

  // a countdown ends the cycle after it fires
  AST_FIRE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !busy_q); // R2

endmodule

// File: rtl/ets_seq_ctrl.sv
module ets_seq_ctrl
  import ets_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int CNT_W  = 6,
  parameter int DLY_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [STEP_W-1:0] step_in,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              rise,
  input  logic              fire,
  output logic              tmr_clr,
  output logic              tmr_load,
  output logic [DLY_W-1:0]  tmr_val,
  output logic              conv,
  output logic              done
);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  total_q, total_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [DLY_W-1:0]  acc_q, acc_d;
  logic              conv_q, conv_d;
  logic [CNT_W-1:0]  idx_inc;
  logic              take_trig;
  logic              take_fire;
  logic              en;

  assign idx_inc   = idx_q + CNT_W'(1);
  assign take_trig = !arm && (state_q == ST_ARMED) && rise;
  assign take_fire = !arm && (state_q == ST_WAIT) && fire;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    total_d  = total_q;
    step_d   = step_q;
    acc_d    = acc_q;
    conv_d   = 1'b0;
    tmr_load = 1'b0;
    if (arm) begin
      step_d  = step_in;
      total_d = count_in;
      idx_d   = '0;
      acc_d   = '0;
      state_d = (count_in == '0) ? ST_DONE : ST_ARMED;
    end else if (take_trig) begin
      tmr_load = 1'b1;
      state_d  = ST_WAIT;
    end else if (take_fire) begin
      conv_d  = 1'b1;
      idx_d   = idx_inc;
      acc_d   = acc_q + DLY_W'(step_q);
      state_d = (idx_inc == total_q) ? ST_DONE : ST_ARMED;
    end
  end

  assign en = arm | take_trig | take_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      total_q <= '0;
      step_q  <= '0;
      acc_q   <= '0;
    end else if (en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      total_q <= total_d;
      step_q  <= step_d;
      acc_q   <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
    end else begin
      conv_q <= conv_d;
    end
  end

  assign tmr_clr = arm;
  assign tmr_val = acc_q;
  assign conv    = conv_q;
  assign done    = (state_q == ST_DONE);

  AST_CONV_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    conv |=> !conv); // R2

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= total_q); // R6

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done); // R6

  AST_NO_CONV_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> !conv); // R6

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && count_in != '0) |=> (!done && !conv)); // R8

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && count_in == '0) |=> done); // R7

endmodule

// File: rtl/ets_sample_sequencer.sv
module ets_sample_sequencer #(
  parameter int STEP_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              trig_i,
  output logic              conv_o,
  output logic              done_o
);

  localparam int DLY_W = STEP_W + CNT_W;

  logic             rst_n_s;
  logic             rise;
  logic             fire;
  logic             busy;
  logic             tmr_clr;
  logic             tmr_load;
  logic [DLY_W-1:0] tmr_val;

  ets_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ets_trig_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .trig_async (trig_i),
    .rise       (rise)
  );

  ets_delay_timer #(.W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr      (tmr_clr),
    .load     (tmr_load),
    .load_val (tmr_val),
    .fire     (fire),
    .busy     (busy)
  );

  ets_seq_ctrl #(.STEP_W(STEP_W), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .arm      (arm_i),
    .step_in  (step_i),
    .count_in (count_i),
    .rise     (rise),
    .fire     (fire),
    .tmr_clr  (tmr_clr),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .conv     (conv_o),
    .done     (done_o)
  );

  // a strobe is only raised out of a running countdown
  AST_CONV_FROM_TIMER: assert property (@(posedge clk) disable iff (!rst_n_s)
    conv_o |-> $past(busy)); // R2

endmodule

// File: tb/sim_ets_sample_sequencer.sv
module sim_ets_sample_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int STEP_W = 8;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              arm_i;
  logic [STEP_W-1:0] step_i;
  logic [CNT_W-1:0]  count_i;
  logic              trig_i;
  logic              conv_o;
  logic              done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_conv = 0;
  int conv_at [0:255];
  int done_at = -1;
  logic done_prev = 1'b0;
  int exp_at [0:63];
  int seed_v;

  ets_sample_sequencer #(.STEP_W(STEP_W), .CNT_W(CNT_W)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (arm_i),
    .step_i  (step_i),
    .count_i (count_i),
    .trig_i  (trig_i),
    .conv_o  (conv_o),
    .done_o  (done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (conv_o) begin
      if (n_conv < 256) conv_at[n_conv] = cyc;
      n_conv = n_conv + 1;
    end
    if (done_o && !done_prev) done_at = cyc;
    done_prev = done_o;
  end

  function automatic int exp_conv(int tc, int k, int step);
    return tc + k * step + 4;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clear_log();
    n_conv  = 0;
    done_at = -1;
  endtask

  task automatic do_arm(input int step, input int count);
    step_i  = STEP_W'(step);
    count_i = CNT_W'(count);
    arm_i   = 1'b1;
    tick(1);
    arm_i   = 1'b0;
  endtask

  task automatic pulse(input int width, output int tc);
    tc = cyc;
    trig_i = 1'b1;
    tick(width);
    trig_i = 1'b0;
  endtask

  task automatic run_acq(input int step, input int count, input int maxw, input bit noise);
    int tc;
    int w;
    int base;
    clear_log();
    do_arm(step, count);
    // R10: inputs move after the arm edge
    step_i  = STEP_W'($urandom);
    count_i = CNT_W'($urandom);
    tick(2);
    for (int k = 0; k < count; k++) begin
      w = 1 + ($urandom % maxw);
      pulse(w, tc);
      exp_at[k] = exp_conv(tc, k, step);
      if (noise && k * step >= 8) begin
        tick(1);
        trig_i = 1'b1;
        tick(1);
        trig_i = 1'b0;
      end
      base = tc + k * step + w + 10;
      while (cyc < base) tick(1);
    end
    tick(3);
    chk(n_conv == count, "R2 strobe count per acquisition", n_conv, count);
    for (int k = 0; k < count; k++) begin
      if (k < n_conv) chk(conv_at[k] == exp_at[k], "R3 R10 strobe cycle", conv_at[k], exp_at[k]);
    end
    chk(done_o == 1'b1, "R6 done after last sample", done_o, 1);
    chk(done_at == exp_at[count-1], "R6 done rises with last strobe", done_at, exp_at[count-1]);
    pulse(2, tc);
    tick(step * count + 20);
    chk(n_conv == count, "R6 no strobe after done", n_conv, count);
    chk(done_o == 1'b1, "R6 done held", done_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int tc;
    seed_v  = $urandom(32'd7411);
    rst_n   = 1'b0;
    arm_i   = 1'b0;
    trig_i  = 1'b0;
    step_i  = '0;
    count_i = '0;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state and triggers before the first arm
    chk(conv_o == 1'b0, "R1 conv low after reset", conv_o, 0);
    chk(done_o == 1'b0, "R1 done low after reset", done_o, 0);
    clear_log();
    pulse(2, tc);
    tick(15);
    chk(n_conv == 0, "R1 trigger before arm ignored", n_conv, 0);

    // R7: zero sample total
    clear_log();
    do_arm(5, 0);
    chk(done_o == 1'b1, "R7 done right after zero-count arm", done_o, 1);
    pulse(2, tc);
    tick(20);
    chk(n_conv == 0, "R7 no strobe with zero count", n_conv, 0);

    // R11: zero step
    run_acq(0, 4, 3, 1'b0);

    // R4: long trigger accepted once
    run_acq(20, 2, 10, 1'b0);
    chk(n_conv == 2, "R4 long trigger counted once", n_conv, 2);

    // R5: extra trigger during countdown
    run_acq(12, 5, 2, 1'b1);

    // R8: re-arm aborts a pending countdown
    clear_log();
    do_arm(30, 3);
    tick(2);
    pulse(1, tc);
    tick(10);
    pulse(1, tc);
    tick(10);
    do_arm(5, 2);
    tick(50);
    chk(n_conv == 1, "R8 pending strobe dropped by arm", n_conv, 1);
    chk(done_o == 1'b0, "R8 done low after re-arm", done_o, 0);
    pulse(1, tc);
    tick(10);
    chk(n_conv == 2 && conv_at[1] == tc + 4, "R8 index restarts at zero delay", conv_at[1], tc + 4);

    // R9: arm on the same edge as a trigger edge
    clear_log();
    do_arm(6, 2);
    tick(3);
    tc = cyc;
    trig_i = 1'b1;
    tick(2);
    arm_i = 1'b1;
    tick(1);
    arm_i = 1'b0;
    trig_i = 1'b0;
    tick(15);
    chk(n_conv == 0, "R9 coinciding trigger dropped", n_conv, 0);
    pulse(1, tc);
    tick(10);
    chk(n_conv == 1 && conv_at[0] == tc + 4, "R9 next trigger is sample zero", conv_at[0], tc + 4);

    // random acquisitions
    for (int r = 0; r < 6; r++) begin
      run_acq(int'($urandom % 13), 1 + int'($urandom % 10), 3, 1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule